// File: doc/BRIEF.md
# Segmented Memory Write-Protect Filter

This block sits in front of a 512-byte storage array. It screens every write request against a 3-bit lock code. The code either leaves the whole array open, locks a fraction at the top of the address space, or locks a run of 64-byte pages counted from address zero.

A write that passes the screen goes to the array one cycle later, with its address and data. A write that fails is dropped. In that case the block raises a single-cycle `wr_blocked` pulse, so the caller can count rejected writes. Reads are forwarded with the same one-cycle latency, whatever the lock code is.

The lock code is loaded through its own control port and keeps its value until it is loaded again. It is visible on `lock_code`.

Top module: `wp_filter`

## Requirements
- R1: After reset, `lock_code` is 000, and `mem_we`, `mem_re` and `wr_blocked` are low.
- R2: With lock code 000, every write reaches the array.
- R3: Lock code 001 blocks addresses 180h–1FFh. Code 010 blocks 100h–1FFh. Code 011 blocks every address. Writes to all other addresses pass.
- R4: Lock code 1nn blocks the first 2^nn pages of 64 bytes, starting at address 000h. So 100 blocks up to 03Fh, 101 up to 07Fh, 110 up to 0FFh and 111 up to 1FFh. Writes above the blocked span pass.
- R5: A blocked write leaves the array contents unchanged.
- R6: Each dropped write raises `wr_blocked` for exactly the one cycle after it is accepted. `wr_blocked` and `mem_we` are never high together.
- R7: A write is judged against the lock code held on the cycle it is accepted. A code loaded on that same cycle first applies to the next write.
- R8: A read with `rd_valid` high always produces `mem_re` with the same address on the next cycle, whatever the lock code.
- R9: A write that passes drives `mem_we` high on the next cycle, with the request's address on `mem_waddr` and its data on `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load `cfg_code` into the lock code register |
| cfg_code | input | 3 | New lock code |
| lock_code | output | 3 | Lock code currently in force |
| wr_valid | input | 1 | Write request strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read request strobe |
| rd_addr | input | ADDR_W | Read address |
| mem_we | output | 1 | Write enable to the array |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| mem_re | output | 1 | Read enable to the array |
| mem_raddr | output | ADDR_W | Array read address |
| wr_blocked | output | 1 | One-cycle pulse for each dropped write |

## Verification
The bench builds the block with its default parameters: a 9-bit address, 8-bit data and 64-byte pages. With these values the array is exactly eight pages, so code 111 covers the whole array. Every region edge falls on a real address: 03Fh/040h, 07Fh/080h, 0FFh/100h and 17Fh/180h. The directed sweep writes on both sides of each edge under all eight codes. A same-cycle code load checks the rule that a new code applies only from the next write. Pseudo-random traffic then mixes code changes, reads and writes, and the final array image is compared with the model's image.

// File: rtl/wp_filter.sv
module wp_filter #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_code,
  output logic [2:0]        lock_code,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              wr_blocked
);

  // page index width; at least 3 so that eight pages fit
  localparam int PG_W = ADDR_W - PAGE_W;

  logic [PG_W-1:0] page;
  logic [PG_W:0]   page_lim;
  logic            hit;

  assign page     = wr_addr[ADDR_W-1:PAGE_W];
  assign page_lim = (PG_W+1)'(1) << lock_code[1:0];

  always_comb begin
    case (lock_code)
      3'b000:  hit = 1'b0;
      3'b001:  hit = &wr_addr[ADDR_W-1 -: 2];
      3'b010:  hit = wr_addr[ADDR_W-1];
      3'b011:  hit = 1'b1;
      default: hit = {1'b0, page} < page_lim;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_code  <= 3'b000;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      wr_blocked <= 1'b0;
      mem_waddr  <= '0;
      mem_wdata  <= '0;
      mem_raddr  <= '0;
    end else begin
      if (cfg_we) lock_code <= cfg_code;
      mem_we     <= wr_valid & ~hit;
      wr_blocked <= wr_valid & hit;
      mem_re     <= rd_valid;
      if (wr_valid) begin
        mem_waddr <= wr_addr;
        mem_wdata <= wr_data;
      end
      if (rd_valid) mem_raddr <= rd_addr;
    end
  end

  // R6
  we_blk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && wr_blocked));

  // R6
  blk_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |-> $past(wr_valid));

  // R9
  fwd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(wr_valid) && mem_waddr == $past(wr_addr) && mem_wdata == $past(wr_data)));

  // R8
  rd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> (mem_re && mem_raddr == $past(rd_addr)));

  // R2
  open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && lock_code == 3'b000) |=> mem_we);

  // R3
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && lock_code == 3'b011) |=> wr_blocked);

endmodule

// File: tb/wp_filter_tb.sv
module wp_filter_tb;
  localparam int AW = 9;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_code = 0;
  logic [2:0] lock_code;
  logic wr_valid = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic rd_valid = 0;
  logic [AW-1:0] rd_addr = 0;
  logic mem_we, mem_re, wr_blocked;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata;

  always #2 clk = ~clk;

  wp_filter #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .lock_code(lock_code), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .wr_blocked(wr_blocked));

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit run_cmp = 0;

  logic [DW-1:0] arr [DEPTH];
  logic [DW-1:0] ref_arr [DEPTH];
  int m_code = 0;
  bit e_we = 0, e_re = 0, e_blk = 0;
  int e_waddr = 0, e_wdata = 0, e_raddr = 0;
  int blk_count = 0, exp_blk_count = 0;

  function automatic bit locked(int c, int a);
    case (c)
      0: return 0;
      1: return a >= 384;
      2: return a >= 256;
      3: return 1;
      4: return a < 64;
      5: return a < 128;
      6: return a < 256;
      default: return a < 512;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  initial for (int i = 0; i < DEPTH; i++) begin arr[i] = 0; ref_arr[i] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code <= 0; e_we <= 0; e_re <= 0; e_blk <= 0;
    end else begin
      e_we  <= wr_valid && !locked(m_code, int'(wr_addr));
      e_blk <= wr_valid && locked(m_code, int'(wr_addr));
      if (wr_valid && locked(m_code, int'(wr_addr))) exp_blk_count <= exp_blk_count + 1;
      if (wr_valid) begin e_waddr <= int'(wr_addr); e_wdata <= int'(wr_data); end
      if (wr_valid && !locked(m_code, int'(wr_addr))) ref_arr[wr_addr] <= wr_data;
      e_re <= rd_valid;
      if (rd_valid) e_raddr <= int'(rd_addr);
      if (cfg_we) m_code <= int'(cfg_code);
      if (mem_we) arr[mem_waddr] <= mem_wdata;
      if (wr_blocked) blk_count <= blk_count + 1;
    end
  end

  always @(negedge clk) if (run_cmp) begin
    string tag;
    tag = (m_code == 0) ? "R2" : (m_code < 4) ? "R3" : "R4";
    check(tag, int'(mem_we), int'(e_we));
    check("R6", int'(wr_blocked), int'(e_blk));
    check("R8", int'(mem_re), int'(e_re));
    if (e_re) check("R8 addr", int'(mem_raddr), e_raddr);
    if (e_we) begin
      check("R9 addr", int'(mem_waddr), e_waddr);
      check("R9 data", int'(mem_wdata), e_wdata);
    end
  end

  task automatic tick; @(negedge clk); endtask

  task automatic set_code(int c);
    cfg_we = 1; cfg_code = 3'(c); tick; cfg_we = 0;
  endtask

  task automatic wr(int a, int d);
    wr_valid = 1; wr_addr = AW'(a); wr_data = DW'(d);
    rd_valid = 1; rd_addr = AW'(a ^ 9'h155);
    tick;
    wr_valid = 0; rd_valid = 0;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up;
  end

  initial begin
    int edges [10] = '{'h000, 'h03F, 'h040, 'h07F, 'h080, 'h0FF, 'h100, 'h17F, 'h180, 'h1FF};
    int seed = 32'h1234_5678;
    repeat (3) tick;
    // R1 reset state
    check("R1 code", int'(lock_code), 0);
    check("R1 we", int'(mem_we), 0);
    check("R1 re", int'(mem_re), 0);
    check("R1 blk", int'(wr_blocked), 0);
    rst_n = 1; tick;
    run_cmp = 1;
    for (int c = 0; c < 8; c++) begin
      set_code(c);
      for (int k = 0; k < 10; k++) wr(edges[k], (c * 16 + k + 1) & 8'hFF);
      tick;
    end
    // R7: same-cycle load of code 011 does not affect the write accepted with it
    set_code(0);
    cfg_we = 1; cfg_code = 3'b011;
    wr_valid = 1; wr_addr = 9'h005; wr_data = 8'hA5;
    @(posedge clk); #1;
    check("R7 same-cycle pass", int'(mem_we), 1);
    tick; cfg_we = 0;
    wr_valid = 1; wr_addr = 9'h006; wr_data = 8'h5A;
    @(posedge clk); #1;
    check("R7 next write blocked", int'(wr_blocked), 1);
    tick; wr_valid = 0; tick;
    for (int n = 0; n < 3000; n++) begin
      seed = seed * 1103515245 + 12345;
      cfg_we   = (seed[7:4] == 4'h0);
      cfg_code = seed[18:16];
      wr_valid = seed[20];
      wr_addr  = seed[30:22];
      wr_data  = seed[15:8];
      rd_valid = seed[21];
      rd_addr  = seed[29:21];
      tick;
    end
    cfg_we = 0; wr_valid = 0; rd_valid = 0;
    repeat (3) tick;
    // R5 array image
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) if (arr[i] != ref_arr[i]) begin
        if (bad == 0) check("R5 array", int'(arr[i]), int'(ref_arr[i]));
        bad++;
      end
      if (bad == 0) check("R5 array", 0, 0);
    end
    // R6 rejected-write count
    check("R6 count", blk_count, exp_blk_count);
    finish_up;
  end
endmodule